// File: doc/BRIEF.md
# ALU Operation Selector

This block turns a coarse operation class, produced by an upstream instruction decoder, into the 3-bit code that steers a 32-bit ALU. The class tells the selector whether the current instruction works on two registers or belongs to the immediate, load/store or branch group. For register-register instructions the selector reads the instruction's 6-bit function field and picks the arithmetic or logic operation from it. For every other class the class code alone fixes the operation, and the function field is ignored.

The selector has no clock and no reset. Its output is valid one combinational delay after its inputs settle. The class input is three bits wide. Two bits would cover the immediate classes in use today, and the third bit leaves room for a future AND-with-immediate class. By default only the low nibble of the function field takes part in the decode. Setting a parameter makes the decoder match all six bits instead.

Top module: `alu_op_selector`

## Requirements
- R1: With class 3'b100 and function nibble 4'b0000 (full field 6'b100000), the output is the add code 3'b000.
- R2: With class 3'b100 and function nibble 4'b0010 (full field 6'b100010), the output is the subtract code 3'b001.
- R3: With class 3'b100 and function nibble 4'b0100 (full field 6'b100100), the output is the bitwise-and code 3'b010.
- R4: With class 3'b100 and function nibble 4'b0101 (full field 6'b100101), the output is the bitwise-or code 3'b110.
- R5: With class 3'b100 and function nibble 4'b1010 (full field 6'b101010), the output is the set-on-less-than code 3'b111.
- R6: In the default low-nibble mode, function bits 5 and 4 have no effect on the output for class 3'b100.
- R7: With class 3'b100 and any function nibble not listed in R1 to R5, the output is the add code 3'b000.
- R8: Class 3'b010 gives the bitwise-or code 3'b110 for every function value.
- R9: Class 3'b000 gives the add code 3'b000 for every function value.
- R10: Class 3'b001 gives the subtract code 3'b001 for every function value.
- R11: The unassigned classes 3'b011, 3'b101, 3'b110 and 3'b111 give the add code 3'b000 for every function value.
- R12: The output is always one of the five codes 3'b000, 3'b001, 3'b010, 3'b110 or 3'b111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | CLASS_W (3) | Operation class from the upstream decoder |
| funct_i | input | FUNCT_W (6) | Function field of the current instruction |
| alu_ctl_o | output | 3 | Operation code for the ALU |

## Verification
The bench applies all 512 pairs of class and function value. Each result is compared with a behavioural model. Sweeping the function field under each fixed class shows that the field is ignored there. The same sweep shows that unassigned classes fall back to add. Under the register-register class, the 64 function values include the five defined codes, their aliases with bits 5 and 4 changed, and every unlisted nibble. Together these separate a correct nibble decode from one that checks the wrong bits or lets undefined codes leak through.

// File: rtl/alu_op_pkg.sv
package alu_op_pkg;

   localparam int unsigned CTL_W      = 3;
   localparam int unsigned MIN_CLS_W  = 3;
   localparam int unsigned MIN_FN_W   = 6;
   localparam int unsigned NIBBLE_W   = 4;

   typedef enum logic [CTL_W-1:0] {
      ALU_ADD = 3'b000,
      ALU_SUB = 3'b001,
      ALU_AND = 3'b010,
      ALU_OR  = 3'b110,
      ALU_SLT = 3'b111
   } alu_ctl_e;

   localparam logic [MIN_CLS_W-1:0] CLS_REGREG = 3'b100;
   localparam logic [MIN_CLS_W-1:0] CLS_OR     = 3'b010;
   localparam logic [MIN_CLS_W-1:0] CLS_ADD    = 3'b000;
   localparam logic [MIN_CLS_W-1:0] CLS_SUB    = 3'b001;

   localparam logic [NIBBLE_W-1:0] FN_ADD = 4'b0000;
   localparam logic [NIBBLE_W-1:0] FN_SUB = 4'b0010;
   localparam logic [NIBBLE_W-1:0] FN_AND = 4'b0100;
   localparam logic [NIBBLE_W-1:0] FN_OR  = 4'b0101;
   localparam logic [NIBBLE_W-1:0] FN_SLT = 4'b1010;

   localparam logic [1:0] FN_HI = 2'b10;

   function automatic logic is_legal_ctl(input logic [CTL_W-1:0] c);
      return (c == ALU_ADD) || (c == ALU_SUB) || (c == ALU_AND) ||
             (c == ALU_OR)  || (c == ALU_SLT);
   endfunction

endpackage

// File: rtl/alu_funct_decode.sv
module alu_funct_decode
   import alu_op_pkg::*;
#(
   parameter int unsigned FUNCT_W  = 6,
   parameter bit          LOW_ONLY = 1'b1
) (
   input  logic [FUNCT_W-1:0] funct_i,
   output alu_ctl_e           op_o
);

   localparam int unsigned EXTRA_W = FUNCT_W - NIBBLE_W;

   if (FUNCT_W < MIN_FN_W) begin : g_bad_width
      $error("alu_funct_decode: FUNCT_W must be at least 6");
   end

   logic [NIBBLE_W-1:0] nib;
   logic [EXTRA_W-1:0]  upper;
   logic                upper_ok;

   assign nib   = funct_i[NIBBLE_W-1:0];
   assign upper = funct_i[FUNCT_W-1:NIBBLE_W];

   if (LOW_ONLY) begin : g_low_nibble
      assign upper_ok = 1'b1;
   end else begin : g_full_field
      assign upper_ok = (upper == EXTRA_W'(FN_HI));
   end

   always_comb begin
      op_o = ALU_ADD;
      if (upper_ok) begin
         unique case (nib)
            FN_SUB:  op_o = ALU_SUB;
            FN_AND:  op_o = ALU_AND;
            FN_OR:   op_o = ALU_OR;
            FN_SLT:  op_o = ALU_SLT;
            default: op_o = ALU_ADD;
         endcase
      end
   end

   // R5: set-on-less-than can only come from its own nibble
   always_comb begin
      if (op_o == ALU_SLT) begin
         a_r5_slt_source : assert final (nib == FN_SLT)
            else $error("a_r5_slt_source: set-on-less-than from nibble %b", nib);
      end
   end

endmodule

// File: rtl/alu_class_decode.sv
module alu_class_decode
   import alu_op_pkg::*;
#(
   parameter int unsigned CLASS_W = 3
) (
   input  logic [CLASS_W-1:0] op_class_i,
   output logic               use_funct_o,
   output alu_ctl_e           fixed_op_o
);

   if (CLASS_W < MIN_CLS_W) begin : g_bad_width
      $error("alu_class_decode: CLASS_W must be at least 3");
   end

   logic                 hi_zero;
   logic [MIN_CLS_W-1:0] code;

   assign code = op_class_i[MIN_CLS_W-1:0];

   if (CLASS_W > MIN_CLS_W) begin : g_wide
      assign hi_zero = (op_class_i[CLASS_W-1:MIN_CLS_W] == '0);
   end else begin : g_exact
      assign hi_zero = 1'b1;
   end

   always_comb begin
      use_funct_o = 1'b0;
      fixed_op_o  = ALU_ADD;
      if (hi_zero) begin
         unique case (code)
            CLS_REGREG: use_funct_o = 1'b1;
            CLS_OR:     fixed_op_o  = ALU_OR;
            CLS_SUB:    fixed_op_o  = ALU_SUB;
            default:    fixed_op_o  = ALU_ADD;
         endcase
      end
   end

   // R11: a fixed class never produces and or set-on-less-than
   always_comb begin
      a_r11_fixed_range : assert final (fixed_op_o != ALU_AND && fixed_op_o != ALU_SLT)
         else $error("a_r11_fixed_range: fixed op %b", fixed_op_o);
   end

endmodule

// File: rtl/alu_op_selector.sv
module alu_op_selector
   import alu_op_pkg::*;
#(
   parameter int unsigned CLASS_W  = 3,
   parameter int unsigned FUNCT_W  = 6,
   parameter bit          LOW_ONLY = 1'b1
) (
   input  logic [CLASS_W-1:0] op_class_i,
   input  logic [FUNCT_W-1:0] funct_i,
   output logic [CTL_W-1:0]   alu_ctl_o
);

   logic     use_funct;
   alu_ctl_e fixed_op;
   alu_ctl_e funct_op;

   alu_class_decode #(.CLASS_W(CLASS_W)) i_class (
      .op_class_i  (op_class_i),
      .use_funct_o (use_funct),
      .fixed_op_o  (fixed_op)
   );

   alu_funct_decode #(.FUNCT_W(FUNCT_W), .LOW_ONLY(LOW_ONLY)) i_funct (
      .funct_i (funct_i),
      .op_o    (funct_op)
   );

   assign alu_ctl_o = use_funct ? funct_op : fixed_op;

   always_comb begin
      // R12: only the five defined codes leave the block
      a_r12_legal_code : assert final (is_legal_ctl(alu_ctl_o))
         else $error("a_r12_legal_code: code %b", alu_ctl_o);
      // R8: the or class ignores the function field
      if (op_class_i == CLASS_W'(CLS_OR)) begin
         a_r8_or_class : assert final (alu_ctl_o == ALU_OR)
            else $error("a_r8_or_class: code %b", alu_ctl_o);
      end
      // R10: the subtract class ignores the function field
      if (op_class_i == CLASS_W'(CLS_SUB)) begin
         a_r10_sub_class : assert final (alu_ctl_o == ALU_SUB)
            else $error("a_r10_sub_class: code %b", alu_ctl_o);
      end
   end

endmodule

// File: tb/test_alu_op_selector.sv
`timescale 1ns/1ps
module test_alu_op_selector;

   logic       clk = 1'b0;
   logic [2:0] op_class;
   logic [5:0] funct;
   logic [2:0] alu_ctl;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   alu_op_selector i_alu_op_selector (
      .op_class_i (op_class),
      .funct_i    (funct),
      .alu_ctl_o  (alu_ctl)
   );

   function automatic int model(input int c, input int f);
      int nib;
      nib = f % 16;
      if (c == 4) begin
         if (nib == 2)       return 1;
         else if (nib == 4)  return 2;
         else if (nib == 5)  return 6;
         else if (nib == 10) return 7;
         else                return 0;
      end
      if (c == 2) return 6;
      if (c == 1) return 1;
      return 0;
   endfunction

   function automatic string req_of(input int c, input int f);
      int nib;
      nib = f % 16;
      if (c == 4) begin
         if (f / 16 != 2) return "R6";
         if (nib == 0)  return "R1";
         if (nib == 2)  return "R2";
         if (nib == 4)  return "R3";
         if (nib == 5)  return "R4";
         if (nib == 10) return "R5";
         return "R7";
      end
      if (c == 2) return "R8";
      if (c == 0) return "R9";
      if (c == 1) return "R10";
      return "R11";
   endfunction

   task automatic apply(input int c, input int f);
      int exp;
      @(posedge clk);
      #1;
      op_class = 3'(c);
      funct    = 6'(f);
      @(negedge clk);
      exp = model(c, f);
      checks++;
      if (int'(alu_ctl) != exp) begin
         errors++;
         $display("FAIL %s class=%b funct=%b actual=%b expected=%b",
                  req_of(c, f), 3'(c), 6'(f), alu_ctl, 3'(exp));
      end
      // R12: every output is one of the five legal codes
      checks++;
      if (!(alu_ctl inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111})) begin
         errors++;
         $display("FAIL R12 actual=%b expected=legal code", alu_ctl);
      end
   endtask

   initial begin
      op_class = '0;
      funct    = '0;
      for (int c = 0; c < 8; c++) begin
         for (int f = 0; f < 64; f++) begin
            apply(c, f);
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule